// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block produces the raster timing for a display from counts that are set at run time. The horizontal and vertical directions each step through four segments: sync, back porch, active and front porch. Each segment length is supplied as its cycle or line count minus one. The horizontal sequencer advances on every pixel clock. The vertical sequencer advances once at the end of every line.

From the two sequencers the block decodes several outputs: horizontal sync, vertical sync, composite sync, blanking, an active-video strobe with pixel and line coordinates, and a one-cycle end-of-frame pulse. Downstream logic such as page or palette switching can use that pulse. Each of the four video outputs has its own polarity bit.

The block keeps two sticky flags, one for horizontal sync and one for vertical sync. Each flag has an enable and a write-one-to-clear strobe, and the enabled flags are merged into one interrupt line. All logic runs on the pixel clock with a synchronous active-high reset.

Each sequencer is a state machine with four states: SYNC, BACK, ACTIVE and FRONT. The transitions are SYNC→BACK, BACK→ACTIVE, ACTIVE→FRONT and FRONT→SYNC. Each transition is taken on an advance when the segment counter equals that segment's programmed length. When a transition is taken, the counter restarts from zero.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset the horizontal sequence repeats with period (h_sync_len+1)+(h_back_len+1)+(h_act_len+1)+(h_front_len+1) cycles. Internal horizontal sync is high for the first h_sync_len+1 cycles of each line.
- R2: The vertical sequence advances one line per horizontal period, with the same four-segment order using the v_* lengths. Internal vertical sync is high during the first v_sync_len+1 lines of each frame.
- R3: Internal composite sync equals the XOR of the internal horizontal and vertical syncs, before any polarity is applied.
- R4: Internal blanking is high whenever either axis is outside its active segment. `active` is the inverse of internal blanking. When `active` is high, `pix_x`/`pix_y` give the offset inside the active segment; otherwise they read 0.
- R5: Each of `pol_hsync`, `pol_vsync`, `pol_csync` and `pol_blank` acts independently. With 0 the output equals its internal active-high signal; with 1 the output is inverted.
- R6: `eof` is high for exactly one cycle per frame: the last front-porch cycle of the last front-porch line.
- R7: The timing inputs are captured during reset and in the `eof` cycle only. A change made mid-frame has no effect until the next frame begins.
- R8: `flag_h` becomes 1 in the first cycle of every horizontal sync. `flag_v` becomes 1 in the first cycle of every frame. Both stay set until cleared.
- R9: A 1 on `irq_clr_h` or `irq_clr_v` clears that flag on the next cycle. If a set event falls in the same cycle as the clear, the set wins.
- R10: `irq` is high exactly when (`flag_h` and `irq_en_h`) or (`flag_v` and `irq_en_v`).
- R11: While `rst` is high, both axes sit at count 0 of SYNC, both flags are 0 and `eof` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_sync_len | input | CW | Horizontal sync length minus one |
| h_back_len | input | CW | Horizontal back porch length minus one |
| h_act_len | input | CW | Horizontal active length minus one |
| h_front_len | input | CW | Horizontal front porch length minus one |
| v_sync_len | input | CW | Vertical sync lines minus one |
| v_back_len | input | CW | Vertical back porch lines minus one |
| v_act_len | input | CW | Vertical active lines minus one |
| v_front_len | input | CW | Vertical front porch lines minus one |
| pol_hsync | input | 1 | Invert horizontal sync when 1 |
| pol_vsync | input | 1 | Invert vertical sync when 1 |
| pol_csync | input | 1 | Invert composite sync when 1 |
| pol_blank | input | 1 | Invert blanking when 1 |
| irq_en_h | input | 1 | Enable horizontal flag onto irq |
| irq_en_v | input | 1 | Enable vertical flag onto irq |
| irq_clr_h | input | 1 | Write-one-to-clear strobe for flag_h |
| irq_clr_v | input | 1 | Write-one-to-clear strobe for flag_v |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| blank | output | 1 | Blanking |
| active | output | 1 | Active video strobe |
| pix_x | output | CW | Pixel offset in active line |
| pix_y | output | CW | Line offset in active frame |
| eof | output | 1 | End-of-frame pulse |
| flag_h | output | 1 | Sticky horizontal sync flag |
| flag_v | output | 1 | Sticky vertical sync flag |
| irq | output | 1 | Merged interrupt |

## Verification
Two events can fall on the same cycle at the end of each line. The flag set for the coming sync and a write-one-to-clear strobe both land on that last front-porch cycle. The bench provokes this by pulsing the clear exactly on line-end cycles and by holding the clear high permanently. In both cases it expects the flag to read 1 in the first sync cycle, and the held clear must remove it one cycle later.

A second pair shares the `eof` cycle: the timing-capture point and a host change to the lengths. The bench changes the lengths mid-frame and judges against a model that switches geometry only after `eof`.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Segment order matters: index into the length array equals the encoding.
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_t;

    localparam int unsigned NUM_SEG = 4;
    localparam int unsigned NUM_IRQ = 2;

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [NUM_SEG-1:0][CW-1:0] seg_len,
    output logic                       in_sync,
    output logic                       in_act,
    output logic                       at_end,
    output logic [CW-1:0]              pos
);

    seg_t          seg_q, seg_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seg_done;

    assign seg_done = (cnt_q == seg_len[seg_q]);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        seg_d = seg_q;
        cnt_d = cnt_q;
        if (step) begin
            if (seg_done) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_SYNC:   seg_d = SEG_BACK;
                    SEG_BACK:   seg_d = SEG_ACTIVE;
                    SEG_ACTIVE: seg_d = SEG_FRONT;
                    SEG_FRONT:  seg_d = SEG_SYNC;
                    default:    seg_d = SEG_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        in_sync = 1'b0;
        in_act  = 1'b0;
        at_end  = 1'b0;
        unique case (seg_q)
            SEG_SYNC:   in_sync = 1'b1;
            SEG_BACK:   ;
            SEG_ACTIVE: in_act  = 1'b1;
            SEG_FRONT:  at_end  = seg_done;
            default:    ;
        endcase
        pos = in_act ? cnt_q : '0;
    end

endmodule

// File: rtl/vtg_irq.sv
module vtg_irq
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_evt,
    input  logic [NUM_IRQ-1:0] clr_req,
    input  logic [NUM_IRQ-1:0] enable,
    output logic [NUM_IRQ-1:0] flag,
    output logic               irq
);

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_ch
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)              flag_q <= 1'b0;
            else if (set_evt[gi]) flag_q <= 1'b1;   // set beats clear
            else if (clr_req[gi]) flag_q <= 1'b0;
        end
        assign flag[gi] = flag_q;
    end

    assign irq = |(flag & enable);

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] h_sync_len,
    input  logic [CW-1:0] h_back_len,
    input  logic [CW-1:0] h_act_len,
    input  logic [CW-1:0] h_front_len,
    input  logic [CW-1:0] v_sync_len,
    input  logic [CW-1:0] v_back_len,
    input  logic [CW-1:0] v_act_len,
    input  logic [CW-1:0] v_front_len,
    input  logic          pol_hsync,
    input  logic          pol_vsync,
    input  logic          pol_csync,
    input  logic          pol_blank,
    input  logic          irq_en_h,
    input  logic          irq_en_v,
    input  logic          irq_clr_h,
    input  logic          irq_clr_v,
    output logic          hsync,
    output logic          vsync,
    output logic          csync,
    output logic          blank,
    output logic          active,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          eof,
    output logic          flag_h,
    output logic          flag_v,
    output logic          irq
);

    logic [NUM_SEG-1:0][CW-1:0] h_sh, v_sh;
    logic                       h_sync_i, h_act_i, h_end;
    logic                       v_sync_i, v_act_i, v_end;
    logic [CW-1:0]              h_pos, v_pos;
    logic                       frame_end, vis;
    logic [NUM_IRQ-1:0]         flags;

    assign frame_end = h_end & v_end;

    // Frame-boundary capture of the timing inputs
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            h_sh <= {h_front_len, h_act_len, h_back_len, h_sync_len};
            v_sh <= {v_front_len, v_act_len, v_back_len, v_sync_len};
        end
    end

    vtg_axis #(.CW(CW)) u_hax (
        .clk     (clk),
        .rst     (rst),
        .step    (1'b1),
        .seg_len (h_sh),
        .in_sync (h_sync_i),
        .in_act  (h_act_i),
        .at_end  (h_end),
        .pos     (h_pos)
    );

    vtg_axis #(.CW(CW)) u_vax (
        .clk     (clk),
        .rst     (rst),
        .step    (h_end),
        .seg_len (v_sh),
        .in_sync (v_sync_i),
        .in_act  (v_act_i),
        .at_end  (v_end),
        .pos     (v_pos)
    );

    vtg_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt ({frame_end, h_end}),
        .clr_req ({irq_clr_v, irq_clr_h}),
        .enable  ({irq_en_v, irq_en_h}),
        .flag    (flags),
        .irq     (irq)
    );

    assign vis    = h_act_i & v_act_i;
    assign hsync  = h_sync_i ^ pol_hsync;
    assign vsync  = v_sync_i ^ pol_vsync;
    assign csync  = (h_sync_i ^ v_sync_i) ^ pol_csync;
    assign blank  = ~vis ^ pol_blank;
    assign active = vis;
    assign pix_x  = vis ? h_pos : '0;
    assign pix_y  = vis ? v_pos : '0;
    assign eof    = frame_end;
    assign flag_h = flags[0];
    assign flag_v = flags[1];

endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
    parameter int unsigned CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          pol_hsync,
    input logic          pol_vsync,
    input logic          pol_csync,
    input logic          irq_en_h,
    input logic          irq_en_v,
    input logic          irq_clr_h,
    input logic          hsync,
    input logic          vsync,
    input logic          csync,
    input logic          active,
    input logic          eof,
    input logic          flag_h,
    input logic          flag_v,
    input logic          irq,
    input logic          h_end,
    input logic [4*CW-1:0] h_sh,
    input logic [4*CW-1:0] v_sh
);

    assert_active_nosync_R1: assert property (@(posedge clk) disable iff (rst)
        active |-> (hsync == pol_hsync) && (vsync == pol_vsync));

    assert_csync_idle_R3: assert property (@(posedge clk) disable iff (rst)
        ((hsync == pol_hsync) && (vsync == pol_vsync)) |-> (csync == pol_csync));

    assert_eof_single_R6: assert property (@(posedge clk) disable iff (rst)
        eof |=> !eof);

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !eof |=> ($stable(h_sh) && $stable(v_sh)));

    assert_flags_set_R8: assert property (@(posedge clk) disable iff (rst)
        eof |=> (flag_h && flag_v));

    assert_clear_h_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_h && !h_end) |=> !flag_h);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_h && !irq_en_v) |-> !irq);

endmodule

bind vid_timing_gen vid_timing_gen_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pol_hsync (pol_hsync),
    .pol_vsync (pol_vsync),
    .pol_csync (pol_csync),
    .irq_en_h  (irq_en_h),
    .irq_en_v  (irq_en_v),
    .irq_clr_h (irq_clr_h),
    .hsync     (hsync),
    .vsync     (vsync),
    .csync     (csync),
    .active    (active),
    .eof       (eof),
    .flag_h    (flag_h),
    .flag_v    (flag_v),
    .irq       (irq),
    .h_end     (h_end),
    .h_sh      (h_sh),
    .v_sh      (v_sh)
);

// File: tb/vid_timing_gen_test.sv
module vid_timing_gen_test;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [CW-1:0] hlen [4];
    logic [CW-1:0] vlen [4];
    logic pol_h = 0, pol_v = 0, pol_c = 0, pol_b = 0;
    logic en_h = 1, en_v = 1, clr_h = 0, clr_v = 0;

    logic hsync, vsync, csync, blank, active, eof, flag_h, flag_v, irq;
    logic [CW-1:0] pix_x, pix_y;

    vid_timing_gen #(.CW(CW)) uut (
        .clk(clk), .rst(rst),
        .h_sync_len(hlen[0]), .h_back_len(hlen[1]), .h_act_len(hlen[2]), .h_front_len(hlen[3]),
        .v_sync_len(vlen[0]), .v_back_len(vlen[1]), .v_act_len(vlen[2]), .v_front_len(vlen[3]),
        .pol_hsync(pol_h), .pol_vsync(pol_v), .pol_csync(pol_c), .pol_blank(pol_b),
        .irq_en_h(en_h), .irq_en_v(en_v), .irq_clr_h(clr_h), .irq_clr_v(clr_v),
        .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank), .active(active),
        .pix_x(pix_x), .pix_y(pix_y), .eof(eof), .flag_h(flag_h), .flag_v(flag_v), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    int ft;
    int ch [4];
    int cv [4];
    logic efh, efv;

    task automatic chk(string scen, string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] %s %s: actual %0d expected %0d (frame cycle %0d)",
                     scen, req, what, act, exp, ft);
        end
    endtask

    task automatic latch_cfg();
        for (int i = 0; i < 4; i++) begin
            ch[i] = int'(hlen[i]) + 1;
            cv[i] = int'(vlen[i]) + 1;
        end
    endtask

    task automatic set_cfg(int h0, int h1, int h2, int h3, int v0, int v1, int v2, int v3);
        hlen[0] = CW'(h0 - 1); hlen[1] = CW'(h1 - 1); hlen[2] = CW'(h2 - 1); hlen[3] = CW'(h3 - 1);
        vlen[0] = CW'(v0 - 1); vlen[1] = CW'(v1 - 1); vlen[2] = CW'(v2 - 1); vlen[3] = CW'(v3 - 1);
    endtask

    // clr_mode: 0 none, 1 hold both clears, 2 clears only on line-end cycles, 3 clear h mid-line
    task automatic run(string scen, int n, int clr_mode);
        for (int k = 0; k < n; k++) begin
            int ht, vt, px, ln;
            logic hs, vs, ha, va, le, fe, vis;
            #1;
            ht = ch[0] + ch[1] + ch[2] + ch[3];
            vt = cv[0] + cv[1] + cv[2] + cv[3];
            px = ft % ht;
            ln = ft / ht;
            hs = (px < ch[0]);
            ha = (px >= ch[0] + ch[1]) && (px < ch[0] + ch[1] + ch[2]);
            vs = (ln < cv[0]);
            va = (ln >= cv[0] + cv[1]) && (ln < cv[0] + cv[1] + cv[2]);
            le = (px == ht - 1);
            fe = le && (ln == vt - 1);
            vis = ha && va;
            chk(scen, "R1", "hsync", int'(hsync), int'(hs ^ pol_h));
            chk(scen, "R2", "vsync", int'(vsync), int'(vs ^ pol_v));
            chk(scen, "R3", "csync", int'(csync), int'(hs ^ vs ^ pol_c));
            chk(scen, "R4", "blank", int'(blank), int'(!vis ^ pol_b));
            chk(scen, "R4", "active", int'(active), int'(vis));
            chk(scen, "R4", "pix_x", int'(pix_x), vis ? px - ch[0] - ch[1] : 0);
            chk(scen, "R4", "pix_y", int'(pix_y), vis ? ln - cv[0] - cv[1] : 0);
            chk(scen, "R6", "eof", int'(eof), int'(fe));
            chk(scen, "R8", "flag_h", int'(flag_h), int'(efh));
            chk(scen, "R8", "flag_v", int'(flag_v), int'(efv));
            chk(scen, "R10", "irq", int'(irq), int'((efh && en_h) || (efv && en_v)));
            unique case (clr_mode)
                1: begin clr_h = 1'b1; clr_v = 1'b1; end
                2: begin clr_h = le;   clr_v = le;   end
                3: begin clr_h = (px == ch[0] + 1); clr_v = 1'b0; end
                default: begin clr_h = 1'b0; clr_v = 1'b0; end
            endcase
            efh = le ? 1'b1 : (clr_h ? 1'b0 : efh);
            efv = fe ? 1'b1 : (clr_v ? 1'b0 : efv);
            if (fe) begin
                ft = 0;
                latch_cfg();
            end else begin
                ft++;
            end
            @(negedge clk);
        end
        clr_h = 1'b0;
        clr_v = 1'b0;
    endtask

    task automatic t_reset();  // R11
        set_cfg(2, 1, 4, 2, 1, 1, 3, 1);
        repeat (3) @(negedge clk);
        #1;
        chk("reset", "R11", "hsync", int'(hsync), 1);
        chk("reset", "R11", "vsync", int'(vsync), 1);
        chk("reset", "R11", "csync", int'(csync), 0);
        chk("reset", "R11", "blank", int'(blank), 1);
        chk("reset", "R11", "eof", int'(eof), 0);
        chk("reset", "R11", "flags", int'({flag_h, flag_v}), 0);
        chk("reset", "R11", "irq", int'(irq), 0);
        rst = 1'b0;
        latch_cfg();
        ft = 0; efh = 1'b0; efv = 1'b0;
    endtask

    task automatic t_basic();  // R1 R2 R3 R4 R6 R8
        run("basic", 120, 0);
    endtask

    task automatic t_polarity();  // R5
        pol_h = 1; pol_v = 0; pol_c = 1; pol_b = 0;
        run("R5_a", 60, 0);
        pol_h = 0; pol_v = 1; pol_c = 0; pol_b = 1;
        run("R5_b", 60, 0);
        pol_h = 0; pol_v = 0; pol_c = 0; pol_b = 0;
    endtask

    task automatic t_midframe();  // R7
        run("R7_pre", 20, 0);
        set_cfg(3, 2, 5, 1, 2, 1, 2, 2);
        run("R7_post", 200, 0);
    endtask

    task automatic t_clear();  // R9
        run("R9_mid", 80, 3);
        run("R9_collide", 80, 2);
        run("R9_hold", 80, 1);
        run("R9_after", 30, 0);
    endtask

    task automatic t_mask();  // R10
        en_h = 0; en_v = 1;
        run("R10_v", 80, 0);
        en_h = 1; en_v = 0;
        run("R10_h", 80, 0);
        en_h = 0; en_v = 0;
        run("R10_off", 80, 0);
        en_h = 1; en_v = 1;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_polarity();
        t_midframe();
        t_clear();
        t_mask();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule